// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Frame-Paced Flow Control

This block recovers bytes from an asynchronous serial line. A programmable divider turns the system clock into a sampling tick, and every bit period lasts sixteen ticks. The divider runs only while a frame is in progress. A falling edge on the synchronized line starts it. The candidate start bit is sampled again halfway through its period. If the line is still low, the data bits are shifted in, least significant bit first, and a single stop bit follows. If the line has returned high, the attempt is discarded.

The assembled byte goes into a parallel holding register. Two flags are raised when this happens: a completion flag and a separate interrupt request. Reading the byte clears the completion flag. The interrupt request is cleared on its own, either by an acknowledge or by a software clear. An active-low ready output paces the sender one frame at a time. It goes low when reception is enabled. It goes high once a start bit is confirmed. It returns low when the byte is read or when a false start is rejected.

Top module: `serial_rx_flow`

## Requirements
- R1: After reset, rts_o is 1, and rx_done_o, irq_o, frame_err_o and rx_data_o are all 0.
- R2: When rx_en_i is asserted after being low, rts_o goes to 0.
- R3: A tick occurs every div_i+1 clocks, and a bit period is 16 ticks. Serial bits arrive least significant first, and after the frame rx_data_o holds the byte.
- R4: Once the start bit is confirmed low at its 8th tick, rts_o goes to 1 and stays 1 for the rest of the frame.
- R5: If the line is high at the start-bit check, the frame is discarded. rts_o goes to 0, and rx_done_o and rx_data_o are left unchanged.
- R6: When the byte is transferred into rx_data_o, rx_done_o and irq_o both become 1 on the same clock.
- R7: A one-clock pulse on rd_i clears rx_done_o and drives rts_o to 0.
- R8: irq_o is cleared by irq_ack_i or by irq_clr_i. Neither input changes rx_done_o, and rd_i does not clear irq_o.
- R9: A low line at the stop-bit midpoint sets frame_err_o, and the byte is still transferred. frame_err_o stays set until rd_i clears it.
- R10: While rx_en_i is 0, rts_o is 1 and incoming frames are ignored, so rx_done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Divider value; one tick every div_i+1 clocks |
| rx_en_i | input | 1 | Receive enable |
| rxd_i | input | 1 | Serial data line, idle high |
| rd_i | input | 1 | Read strobe for the received byte |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_clr_i | input | 1 | Software clear of the interrupt request |
| rx_data_o | output | DATA_W | Received byte |
| rx_done_o | output | 1 | Byte-available flag |
| irq_o | output | 1 | Interrupt request |
| frame_err_o | output | 1 | Sticky stop-bit error flag |
| rts_o | output | 1 | Flow control, low means ready |

## Verification
The hardest case to reach is a false-start rejection that can be seen at the ports. rts_o is already low in the idle state, so a rejection would normally leave no trace. To make it visible, the bench first receives a complete byte and does not read it, which leaves rts_o high. It then sends a low pulse shorter than half a bit. The rejection must then pull rts_o low while the unread byte and its completion flag stay unchanged. Framing errors are produced from the vector table by driving a low stop bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) chain <= '1;
            else         chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} ;
         end
         assign q_o = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i)  cnt <= '0;
      else if (cnt == div_i)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   assign tick_o = run_i && (cnt == div_i);
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              rxd_i,
   input  logic              tick_i,
   output logic              run_o,
   output logic              start_ok_o,
   output logic              start_bad_o,
   output logic              load_o,
   output logic              stop_bad_o,
   output logic [DATA_W-1:0] shift_o
);
   localparam int SUB_W = $clog2(OVERSAMPLE);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [SUB_W-1:0] VERIFY_AT = SUB_W'(OVERSAMPLE / 2 - 1);
   localparam logic [SUB_W-1:0] MID_AT    = SUB_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);

   srx_state_e        state;
   logic [SUB_W-1:0]  sub;
   logic [CNT_W-1:0]  bitn;
   logic [DATA_W-1:0] shreg;
   logic              rxd_q;
   logic              fall;
   logic              verify_pt;
   logic              mid_pt;

   assign fall      = rxd_q && !rxd_i;
   assign verify_pt = tick_i && (sub == VERIFY_AT);
   assign mid_pt    = tick_i && (sub == MID_AT);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state <= ST_IDLE;
         sub   <= '0;
         bitn  <= '0;
         shreg <= '0;
         rxd_q <= 1'b1;
      end else begin
         rxd_q <= rxd_i;
         if (!en_i) begin
            state <= ST_IDLE;
            sub   <= '0;
         end else begin
            unique case (state)
               ST_IDLE: if (fall) begin
                  state <= ST_START;
                  sub   <= '0;
               end
               ST_START: if (verify_pt) begin
                  sub   <= '0;
                  bitn  <= '0;
                  state <= rxd_i ? ST_IDLE : ST_DATA;
               end else if (tick_i) begin
                  sub <= sub + 1'b1;
               end
               ST_DATA: if (mid_pt) begin
                  sub   <= '0;
                  shreg <= {rxd_i, shreg[DATA_W-1:1]};
                  if (bitn == LAST_BIT) state <= ST_STOP;
                  else                  bitn  <= bitn + 1'b1;
               end else if (tick_i) begin
                  sub <= sub + 1'b1;
               end
               ST_STOP: if (mid_pt) begin
                  sub   <= '0;
                  state <= ST_IDLE;
               end else if (tick_i) begin
                  sub <= sub + 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign run_o       = (state != ST_IDLE);
   assign start_ok_o  = en_i && (state == ST_START) && verify_pt && !rxd_i;
   assign start_bad_o = en_i && (state == ST_START) && verify_pt &&  rxd_i;
   assign load_o      = en_i && (state == ST_STOP)  && mid_pt;
   assign stop_bad_o  = !rxd_i;
   assign shift_o     = shreg;
endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              start_ok_i,
   input  logic              start_bad_i,
   input  logic              load_i,
   input  logic              stop_bad_i,
   input  logic [DATA_W-1:0] shift_i,
   input  logic              rd_i,
   input  logic              ack_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o,
   output logic              irq_o,
   output logic              ferr_o,
   output logic              rts_o
);
   logic en_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         data_o <= '0;
         done_o <= 1'b0;
         irq_o  <= 1'b0;
         ferr_o <= 1'b0;
         rts_o  <= 1'b1;
      end else begin
         en_q <= en_i;
         if (load_i) begin
            data_o <= shift_i;
            done_o <= 1'b1;
            if (stop_bad_i) ferr_o <= 1'b1;
         end else if (rd_i) begin
            done_o <= 1'b0;
            ferr_o <= 1'b0;
         end
         if (load_i)              irq_o <= 1'b1;
         else if (ack_i || clr_i) irq_o <= 1'b0;
         if (!en_i)                                  rts_o <= 1'b1;
         else if (start_ok_i)                        rts_o <= 1'b1;
         else if (start_bad_i || rd_i || !en_q)      rts_o <= 1'b0;
      end
   end
endmodule

// File: rtl/serial_rx_flow.sv
module serial_rx_flow #(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              rx_en_i,
   input  logic              rxd_i,
   input  logic              rd_i,
   input  logic              irq_ack_i,
   input  logic              irq_clr_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_done_o,
   output logic              irq_o,
   output logic              frame_err_o,
   output logic              rts_o
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two of at least 4");
      end
      if (DATA_W < 2 || DIV_W < 1 || SYNC_STAGES < 0) begin : g_bad_w
         $error("illegal width or synchronizer depth");
      end
   endgenerate

   logic rxd_s;
   logic run;
   logic tick;
   logic start_ok;
   logic start_bad;
   logic frame_load;
   logic stop_bad;
   logic [DATA_W-1:0] shift;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
   );

   srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div_i), .tick_o(tick)
   );

   srx_frame_fsm #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .rxd_i(rxd_s), .tick_i(tick),
      .run_o(run), .start_ok_o(start_ok), .start_bad_o(start_bad),
      .load_o(frame_load), .stop_bad_o(stop_bad), .shift_o(shift)
   );

   srx_status #(.DATA_W(DATA_W)) u_stat (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i),
      .start_ok_i(start_ok), .start_bad_i(start_bad), .load_i(frame_load),
      .stop_bad_i(stop_bad), .shift_i(shift), .rd_i(rd_i),
      .ack_i(irq_ack_i), .clr_i(irq_clr_i),
      .data_o(rx_data_o), .done_o(rx_done_o), .irq_o(irq_o),
      .ferr_o(frame_err_o), .rts_o(rts_o)
   );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic rx_en_i,
   input logic rd_i,
   input logic irq_ack_i,
   input logic irq_clr_i,
   input logic frame_load,
   input logic start_ok,
   input logic rx_done_o,
   input logic irq_o,
   input logic rts_o
);
   a_r6_load_sets_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_load |=> (rx_done_o && irq_o));

   a_r7_read_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !frame_load) |=> !rx_done_o);

   a_r8_irq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_ack_i || irq_clr_i) && !frame_load) |=> !irq_o);

   a_r8_done_kept_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_ack_i || irq_clr_i) && !rd_i && rx_done_o) |=> rx_done_o);

   a_r10_disabled_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rx_en_i |=> rts_o);

   a_r4_start_raises_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_ok && rx_en_i) |=> rts_o);
endmodule

bind serial_rx_flow srx_checker u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rd_i(rd_i),
   .irq_ack_i(irq_ack_i), .irq_clr_i(irq_clr_i), .frame_load(frame_load),
   .start_ok(start_ok), .rx_done_o(rx_done_o), .irq_o(irq_o), .rts_o(rts_o)
);

// File: tb/serial_rx_flow_test.sv
module serial_rx_flow_test;
   localparam int BITC = 64;   // (div 3 + 1) * 16 clocks per bit

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div = 8'd3;
   logic       en = 1'b0;
   logic       rxd = 1'b1;
   logic       rd = 1'b0;
   logic       ack = 1'b0;
   logic       clr = 1'b0;
   logic [7:0] data;
   logic       done;
   logic       irq;
   logic       ferr;
   logic       rts;
   logic       mid_rts;
   int         checks = 0;
   int         errors = 0;

   always #10 clk = ~clk;

   serial_rx_flow uut (
      .clk_i(clk), .rst_ni(rst_n), .div_i(div), .rx_en_i(en), .rxd_i(rxd),
      .rd_i(rd), .irq_ack_i(ack), .irq_clr_i(clr), .rx_data_o(data),
      .rx_done_o(done), .irq_o(irq), .frame_err_o(ferr), .rts_o(rts)
   );

   // {byte, stop level}
   localparam logic [8:0] VEC [4] = '{
      {8'hA5, 1'b1}, {8'h00, 1'b1}, {8'hFF, 1'b0}, {8'h3C, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, input logic stop);
      rxd = 1'b0; wait_clk(BITC);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         wait_clk(BITC);
         if (i == 1) mid_rts = rts;
      end
      rxd = stop; wait_clk(BITC);
      rxd = 1'b1; wait_clk(BITC);
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; wait_clk(1); s = 1'b0; wait_clk(2);
   endtask

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      chk("R1 rts", rts, 1); chk("R1 done", done, 0); chk("R1 irq", irq, 0);
      chk("R1 ferr", ferr, 0); chk("R1 data", data, 0);

      // R10 disabled receiver ignores a frame
      send(8'h5A, 1'b1);
      chk("R10 done", done, 0); chk("R10 rts", rts, 1);

      // R2 enable makes ready
      en = 1'b1; wait_clk(3);
      chk("R2 rts", rts, 0);

      // vector table: R3 R4 R6 R7 R8 R9
      for (int i = 0; i < 4; i++) begin
         send(VEC[i][8:1], VEC[i][0]);
         chk("R3 data", data, VEC[i][8:1]);
         chk("R4 rts mid-frame", mid_rts, 1);
         chk("R4 rts after frame", rts, 1);
         chk("R6 done", done, 1); chk("R6 irq", irq, 1);
         chk("R9 ferr", ferr, !VEC[i][0]);
         if (i % 2 == 0) pulse(ack); else pulse(clr);
         chk("R8 irq cleared", irq, 0); chk("R8 done kept", done, 1);
         pulse(rd);
         chk("R7 done", done, 0); chk("R7 rts", rts, 0);
         chk("R9 ferr cleared", ferr, 0);
      end

      // R8 read leaves irq
      send(8'h81, 1'b1);
      pulse(rd);
      chk("R8 irq after read", irq, 1);
      pulse(clr);

      // R5 false start with an unread byte pending
      send(8'h96, 1'b1);
      chk("R5 pre rts", rts, 1);
      rxd = 1'b0; wait_clk(8); rxd = 1'b1; wait_clk(2 * BITC);
      chk("R5 rts", rts, 0); chk("R5 done", done, 1); chk("R5 data", data, 8'h96);
      pulse(rd); pulse(ack);

      // R3 different divider
      div = 8'd1;
      begin
         rxd = 1'b0; wait_clk(32);
         for (int i = 0; i < 8; i++) begin rxd = (8'hC3 >> i) & 1; wait_clk(32); end
         rxd = 1'b1; wait_clk(64);
      end
      chk("R3 div1 data", data, 8'hC3); chk("R6 div1 done", done, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule